// File: doc/BRIEF.md
# Bit-Serial Second-Order Recursive Filter

This block evaluates a second-order recursive (IIR) filter. The recurrence is y(i) = a·x(i) + b·x(i−1) + c·x(i−2) + d·y(i−1) + e·y(i−2), and no multiplier is used. The current input, the two previous inputs and the two previous outputs each sit in an operand shift register. These registers are consumed one bit per cycle, least significant bit first. The five bits taken in a cycle form an address into a 32-entry table. That table holds every partial sum of the five coefficients and is computed at elaboration from integer parameters. The selected entry goes into a right-shifting accumulator. It is added on every bit cycle except the last one, which carries the two's complement sign and subtracts. The bit that falls out of the accumulator each cycle enters an output shift register. Once all bits are done, the accumulator and the output shift register together hold the exact sum of products.

A user presents a parallel sample with a valid strobe whenever the block is ready. After `W` cycles the filtered sample appears in parallel with a one-cycle done strobe. At that moment the new input and the new output move into the delay history, and each older value moves back by one position. The coefficients are fixed point with `FRAC` fraction bits. The output is the sum divided by 2^FRAC, rounded toward minus infinity and wrapped to `W` bits.

Top module: `bsiir_top`

## Requirements
- R1: Immediately after reset, `in_ready` is 1, `out_valid` is 0, `out_data` is 0, and all four history values (two inputs and two outputs) are zero.
- R2: A sample accepted at a clock edge yields `out_valid` high for exactly one cycle, starting `W` clock edges later.
- R3: `in_ready` is low from the edge that accepts a sample until the edge that raises `out_valid`. A strobe on `in_valid` during that time has no effect on any later output.
- R4: Let S = CA·x(i) + CB·x(i−1) + CC·x(i−2) + CD·y(i−1) + CE·y(i−2), where every operand is a W-bit two's complement value. Then `out_data` equals floor(S / 2^FRAC), with its low W bits taken as two's complement.
- R5: Each produced sample moves the history along: x(i−1) takes the sample just filtered, x(i−2) takes the old x(i−1), y(i−1) takes the value just output, and y(i−2) takes the old y(i−1). Strobes that were not accepted do not move the history.
- R6: Operands equal to the most negative value (−2^(W−1)) and the most positive value are handled exactly, because the sign-bit cycle subtracts its table entry.
- R7: `out_data` holds its value between done strobes.
- R8: The block is ready again in the cycle where `out_valid` is high. A sample presented then is accepted, so samples held back to back complete every `W`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe; accepted when `in_ready` is high |
| in_data | input | W | Input sample, two's complement |
| in_ready | output | 1 | Block idle, able to accept a sample |
| out_valid | output | 1 | One-cycle strobe marking a new output |
| out_data | output | W | Filtered sample, two's complement, held between strobes |

## Verification
The filter is first driven with an isolated impulse followed by zero inputs. In that case every output after the first comes only from the feedback taps, which shows whether the output history is wired and ordered correctly. Spaced samples of mixed sign and a run at both extreme values test the sign-bit subtraction and the wrap of the result. A stream with `in_valid` held high and the data changing every cycle checks two things: that acceptance happens in the done cycle, and that strobes arriving while busy are ignored. A cycle-level model checks the ready, valid and data outputs on every clock.

// File: rtl/bsiir_pkg.sv
package bsiir_pkg;

  localparam int unsigned NTAPS = 5;
  localparam int unsigned NLUT  = 1 << NTAPS;

  // Partial sum of the coefficients selected by the bits of idx.
  // bit0: x(i), bit1: x(i-1), bit2: x(i-2), bit3: y(i-1), bit4: y(i-2)
  function automatic longint lut_sum(int unsigned idx, int ca, int cb,
                                     int cc, int cd, int ce);
    longint s;
    s = 0;
    if (idx[0]) s += longint'(ca);
    if (idx[1]) s += longint'(cb);
    if (idx[2]) s += longint'(cc);
    if (idx[3]) s += longint'(cd);
    if (idx[4]) s += longint'(ce);
    return s;
  endfunction

endpackage

// File: rtl/bsiir_lut.sv
module bsiir_lut
  import bsiir_pkg::*;
#(
  parameter int AW = 11,
  parameter int CA = 16,
  parameter int CB = 32,
  parameter int CC = 16,
  parameter int CD = 32,
  parameter int CE = -16
) (
  input  logic [NTAPS-1:0]     addr,
  output logic signed [AW-1:0] term
);

  logic signed [AW-1:0] tbl [NLUT];

  for (genvar g = 0; g < NLUT; g++) begin : g_entry
    localparam longint SUMV = lut_sum(g, CA, CB, CC, CD, CE);
    localparam logic signed [AW-1:0] ENTRY = SUMV[AW-1:0];
    assign tbl[g] = ENTRY;
  end

  assign term = tbl[addr];

endmodule

// File: rtl/bsiir_tapsr.sv
module bsiir_tapsr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] load_val,
  output logic         lsb
);

  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = load_val;
    else if (shift) sr_d = {1'b0, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign lsb = sr_q[0];

endmodule

// File: rtl/bsiir_acc.sv
module bsiir_acc #(
  parameter int W  = 8,
  parameter int AW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 neg,
  input  logic signed [AW-1:0] term,
  output logic signed [AW-1:0] acc_nx,
  output logic [W-1:0]         obits_nx
);

  logic signed [AW-1:0] acc_q;
  logic [W-1:0]         obits_q;
  logic signed [AW:0]   addend, sum;

  always_comb begin
    addend   = neg ? -{term[AW-1], term} : {term[AW-1], term};
    sum      = {acc_q[AW-1], acc_q} + addend;
    acc_nx   = acc_q;
    obits_nx = obits_q;
    if (clr) begin
      acc_nx   = '0;
      obits_nx = '0;
    end else if (en) begin
      acc_nx   = sum[AW:1];
      obits_nx = {sum[0], obits_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      obits_q <= '0;
    end else begin
      acc_q   <= acc_nx;
      obits_q <= obits_nx;
    end
  end

  // R4: a clear and a bit step never coincide
  clr_en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && en));

  // R6: a cleared accumulator starts the next sample from zero
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && obits_q == '0));

endmodule

// File: rtl/bsiir_seq.sv
module bsiir_seq #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step,
  output logic sign_bit,
  output logic finish,
  output logic busy,
  output logic done
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic {S_IDLE, S_RUN} st_e;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    accept   = (st_q == S_IDLE) && start;
    step     = (st_q == S_RUN);
    sign_bit = step && (cnt_q == LAST);
    finish   = sign_bit;
    done_d   = finish;
    if (accept) begin
      st_d  = S_RUN;
      cnt_d = '0;
    end else if (step) begin
      if (finish) st_d = S_IDLE;
      else        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy = (st_q == S_RUN);
  assign done = done_q;

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= LAST));

endmodule

// File: rtl/bsiir_top.sv
module bsiir_top
  import bsiir_pkg::*;
#(
  parameter int W    = 8,
  parameter int CWID = 8,
  parameter int FRAC = 6,
  parameter int CA   = 16,
  parameter int CB   = 32,
  parameter int CC   = 16,
  parameter int CD   = 32,
  parameter int CE   = -16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  localparam int AW = CWID + 3;
  localparam int FW = AW + W;

  // reset: asserted at once, released after two clock edges
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic accept, step, sign_bit, finish, busy, done;

  bsiir_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(in_valid), .accept(accept),
    .step(step), .sign_bit(sign_bit), .finish(finish), .busy(busy),
    .done(done)
  );

  // delay history and held current input
  logic [W-1:0] xh1_q, xh2_q, yh1_q, yh2_q, xcur_q;
  logic [W-1:0] xh1_d, xh2_d, yh1_d, yh2_d, xcur_d;
  logic [W-1:0] res_q, res_d, y_new;

  logic [W-1:0]     tap_load [NTAPS];
  logic [NTAPS-1:0] tap_bits;

  assign tap_load[0] = in_data;
  assign tap_load[1] = xh1_q;
  assign tap_load[2] = xh2_q;
  assign tap_load[3] = yh1_q;
  assign tap_load[4] = yh2_q;

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    bsiir_tapsr #(.W(W)) u_sr (
      .clk(clk), .rst_n(rst_s), .load(accept), .shift(step),
      .load_val(tap_load[t]), .lsb(tap_bits[t])
    );
  end

  logic signed [AW-1:0] term, acc_nx;
  logic [W-1:0]         obits_nx;
  logic [FW-1:0]        full_nx;

  bsiir_lut #(.AW(AW), .CA(CA), .CB(CB), .CC(CC), .CD(CD), .CE(CE)) u_lut (
    .addr(tap_bits), .term(term)
  );

  bsiir_acc #(.W(W), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_s), .clr(accept), .en(step), .neg(sign_bit),
    .term(term), .acc_nx(acc_nx), .obits_nx(obits_nx)
  );

  assign full_nx = {acc_nx, obits_nx};
  assign y_new   = full_nx[FRAC +: W];

  always_comb begin
    xh1_d  = xh1_q;
    xh2_d  = xh2_q;
    yh1_d  = yh1_q;
    yh2_d  = yh2_q;
    xcur_d = xcur_q;
    res_d  = res_q;
    if (accept) xcur_d = in_data;
    if (finish) begin
      xh2_d = xh1_q;
      xh1_d = xcur_q;
      yh2_d = yh1_q;
      yh1_d = y_new;
      res_d = y_new;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      xh1_q  <= '0;
      xh2_q  <= '0;
      yh1_q  <= '0;
      yh2_q  <= '0;
      xcur_q <= '0;
      res_q  <= '0;
    end else begin
      xh1_q  <= xh1_d;
      xh2_q  <= xh2_d;
      yh1_q  <= yh1_d;
      yh2_q  <= yh2_d;
      xcur_q <= xcur_d;
      res_q  <= res_d;
    end
  end

  assign in_ready  = !busy;
  assign out_valid = done;
  assign out_data  = res_q;

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !out_valid |-> $stable(out_data));

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> (yh1_q == out_data && yh2_q == $past(yh1_q)));

  // R8
  ready_on_done_chk: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> in_ready);

endmodule

// File: tb/bsiir_top_tb_top.sv
`timescale 1ns/1ps
module bsiir_top_tb_top;

  localparam int W = 8, CWID = 8, FRAC = 6;
  localparam int CA = 16, CB = 32, CC = 16, CD = 32, CE = -16;

  logic clk, rst_n, in_valid, in_ready, out_valid;
  logic [W-1:0] in_data, out_data;

  int total, bad;

  bsiir_top #(.W(W), .CWID(CWID), .FRAC(FRAC), .CA(CA), .CB(CB), .CC(CC),
              .CD(CD), .CE(CE)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference
  longint xq[$], yq[$];
  longint m_data, m_pend;
  int     m_cnt;
  bit     m_busy, m_valid, m_acc;

  function automatic longint sx(logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint filt(longint x0);
    longint s, y;
    s = CA * x0 + CB * xq[0] + CC * xq[1] + CD * yq[0] + CE * yq[1];
    y = (s >>> FRAC) & ((longint'(1) << W) - 1);
    if (y >= (longint'(1) << (W - 1))) y -= (longint'(1) << W);
    return y;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xq = '{0, 0}; yq = '{0, 0};
      m_busy = 0; m_valid = 0; m_data = 0; m_cnt = 0; m_acc = 0;
    end else begin
      m_valid = 0; m_acc = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == W) begin
          m_busy = 0; m_valid = 1; m_data = m_pend;
          yq.push_front(m_pend); void'(yq.pop_back());
        end
      end else if (in_valid) begin
        m_pend = filt(sx(in_data));
        xq.push_front(sx(in_data)); void'(xq.pop_back());
        m_busy = 1; m_cnt = 0; m_acc = 1;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  bit live;
  always @(negedge clk) begin
    if (live) begin
      chk("R3 in_ready", in_ready, !m_busy);
      chk("R2 out_valid", out_valid, m_valid);
      chk("R4/R5/R7 out_data", sx(out_data), m_data);
      if (out_valid) chk("R8 ready in done cycle", in_ready, 1);
    end
  end

  task automatic send(logic [W-1:0] v, int gap);
    @(negedge clk);
    in_valid = 1; in_data = v;
    do begin @(posedge clk); #1; end while (!m_acc);
    in_valid = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0; live = 0;
    in_valid = 0; in_data = '0; rst_n = 0;
    #1;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_data", out_data, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    live = 1;

    // impulse then zeros: R5 feedback and R1 zero history
    send(8'd64, 2);
    for (int i = 0; i < 6; i++) send(8'd0, 1);
    wait_idle();

    // mixed signs, spaced: R4
    send(8'hF3, 0);
    send(8'd37, 3);
    send(8'hA0, 1);
    send(8'd5, 0);
    wait_idle();

    // extremes: R6
    for (int i = 0; i < 4; i++) send(8'h80, 0);
    for (int i = 0; i < 4; i++) send(8'h7F, 0);
    send(8'h80, 0); send(8'h7F, 0); send(8'h80, 2);
    wait_idle();

    // strobes while busy are ignored: R3
    send(8'd20, 0);
    @(negedge clk); in_valid = 1; in_data = 8'h55;
    repeat (W - 3) begin @(negedge clk); in_data = in_data + 8'd7; end
    in_valid = 0;
    wait_idle();
    send(8'd0, 0);
    wait_idle();

    // held valid, data changing every cycle: R8 and R3
    for (int i = 0; i < 90; i++) begin
      @(negedge clk); in_valid = 1; in_data = 8'($urandom);
    end
    @(negedge clk); in_valid = 0;
    wait_idle();
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule